// File: doc/BRIEF.md
# DMA Descriptor Fetch and Transfer Engine

This block services one granted DMA channel at a time. On a start pulse it finds the channel's descriptor slot in a fixed table in memory, reads the three words of the descriptor it uses, and then moves the data one item at a time. Each item is one read from the source and one write to the destination. After every item it writes the updated configuration word back to the slot. An arbiter outside the block supplies the channel index and the primary/alternate select. A register outside the block supplies the upper bits of the table base. All memory traffic goes through a single-beat request/acknowledge port.

A descriptor names the *last* source and destination addresses, not the first. The engine therefore works backward from the remaining-item count to find each current address. The configuration word packs four things: a transfer mode, an item size, two address-step enables, and a remaining count that holds the number of items minus one. When the last item is written back, the mode is cleared so that the slot reads as consumed, and a one-cycle completion pulse is raised. A bad descriptor or a memory error response aborts the work and raises an error pulse instead.

Top module: `dxe_engine`

## Requirements
- R1: The slot address is `{base_hi, 9'b0} + (use_alt ? 0x100 : 0) + chan*0x10`. The engine reads slot+0x0 (source end), then slot+0x4 (destination end), then slot+0x8 (configuration), all at word size. It never accesses slot+0xC.
- R2: The configuration word has these fields: bits[1:0] mode, bits[3:2] size (0 byte, 1 halfword, 2 word), bit[4] source step, bit[5] destination step, bits[15:6] remaining count. The current address is end − remaining×(1, 2 or 4 bytes) when its step bit is 1. It is the end address itself when the step bit is 0.
- R3: Each item is one read at the current source address followed by one write of the same data to the current destination address. Both beats carry `mem_size` equal to the size field.
- R4: After each item's write, the engine writes the configuration word to slot+0x8 with the remaining count reduced by one. All other bits are unchanged. The next item follows.
- R5: For the item fetched with remaining count 0, the write-back has mode bits[1:0] cleared and a count of 0. `done` is then high for exactly one cycle and the engine returns to idle.
- R6: If the fetched configuration has mode 0, the engine raises `err` for one cycle and returns to idle. It makes no data access and no write.
- R7: A beat acknowledged with `mem_err` ends the transfer. `err` pulses in the next cycle and no further beat follows. The configuration in memory keeps the value of the last completed write-back.
- R8: `start` is ignored while `busy` is high.
- R9: While `mem_req` is high and `mem_ack` is low, `mem_addr`, `mem_we`, `mem_wdata` and `mem_size` hold their values into the next cycle.
- R10: After reset the engine is idle, with `busy`, `mem_req`, `done` and `err` low. It never requests memory while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin servicing the given channel (sampled when idle) |
| chan | input | CH_W | Granted channel index |
| use_alt | input | 1 | 1 selects the alternate descriptor half |
| base_hi | input | BASE_W | Table base, address bits 31:9 |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 for a write beat |
| mem_addr | output | 32 | Beat address |
| mem_wdata | output | 32 | Write data |
| mem_size | output | 2 | Beat size: 0 byte, 1 halfword, 2 word |
| mem_ack | input | 1 | Beat accepted this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_err | input | 1 | Error response, valid with `mem_ack` |
| busy | output | 1 | Engine is not idle |
| done | output | 1 | One-cycle pulse: transfer finished |
| err | output | 1 | One-cycle pulse: transfer aborted |

## Verification
Some rules hold on every cycle, and the bound checker watches those. These are the hold of a pending request, the single-cycle completion pulse, the exclusivity of the two pulses, the return to idle after an error response, and the rule that an idle engine makes no request. Other behaviour depends on descriptor contents. This covers the backward address arithmetic for each size and step combination, the slot placement for the primary and alternate halves, the order of beats, and the value written back after each item. Only the bench scenarios show these, through a scoreboard of expected beats that covers the edge slots, a mode-0 descriptor, an error in mid-transfer and a start pulse issued while busy.

// File: rtl/dxe_pkg.sv
package dxe_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } xsize_e;

    localparam int COUNT_W = 10;

    // Configuration word, msb first: spare, count, dst step, src step, size, mode
    typedef struct packed {
        logic [15:0]        spare;
        logic [COUNT_W-1:0] remain;
        logic               dst_step;
        logic               src_step;
        xsize_e             size;
        logic [1:0]         mode;
    } cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GET_SRC,
        ST_GET_DST,
        ST_GET_CFG,
        ST_READ,
        ST_WRITE,
        ST_UPDATE
    } st_e;

    localparam logic [31:0] OFF_SRC = 32'h0;
    localparam logic [31:0] OFF_DST = 32'h4;
    localparam logic [31:0] OFF_CFG = 32'h8;
    localparam logic [31:0] ALT_OFF = 32'h100;
    localparam int          SLOT_SH = 4;

    function automatic logic [1:0] size_shift(xsize_e s);
        return (s == SZ_RSVD) ? 2'd2 : 2'(s);
    endfunction

    function automatic cfg_t advance(cfg_t c);
        cfg_t n;
        n = c;
        if (c.remain == '0) n.mode = 2'b00;
        else                n.remain = c.remain - 1'b1;
        return n;
    endfunction

endpackage

// File: rtl/dxe_slot_addr.sv
module dxe_slot_addr #(
    parameter int NCH    = 16,
    parameter int BASE_W = 23,
    parameter int CH_W   = $clog2(NCH)
) (
    input  logic [BASE_W-1:0] base_hi,
    input  logic [CH_W-1:0]   chan,
    input  logic              use_alt,
    output logic [31:0]       slot
);
    import dxe_pkg::*;

    localparam int LOW_W = 32 - BASE_W;

    always_comb begin
        slot = {base_hi, {LOW_W{1'b0}}}
             + (use_alt ? ALT_OFF : 32'h0)
             + (32'(chan) << SLOT_SH);
    end
endmodule

// File: rtl/dxe_item_addr.sv
module dxe_item_addr
    import dxe_pkg::*;
(
    input  logic [31:0]        end_ptr,
    input  logic [COUNT_W-1:0] remain,
    input  xsize_e             size,
    input  logic               step,
    output logic [31:0]        addr
);
    logic [31:0] back;

    always_comb begin
        back = 32'(remain) << size_shift(size);
        addr = step ? (end_ptr - back) : end_ptr;
    end
endmodule

// File: rtl/dxe_engine.sv
module dxe_engine
    import dxe_pkg::*;
#(
    parameter int NCH    = 16,
    parameter int BASE_W = 23,
    parameter int CH_W   = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CH_W-1:0]   chan,
    input  logic              use_alt,
    input  logic [BASE_W-1:0] base_hi,
    output logic              mem_req,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    output logic [1:0]        mem_size,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_err,
    output logic              busy,
    output logic              done,
    output logic              err
);
    st_e         st_q;
    logic [31:0] slot_q;
    logic [31:0] slot_w;
    logic [31:0] end_q [2];
    logic [31:0] cur_a [2];
    logic [31:0] data_q;
    cfg_t        cfg_q;
    cfg_t        cfg_in;
    cfg_t        cfg_nx;
    logic        beat;

    assign beat   = mem_req && mem_ack;
    assign cfg_in = cfg_t'(mem_rdata);
    assign cfg_nx = advance(cfg_q);
    assign busy   = (st_q != ST_IDLE);

    dxe_slot_addr #(.NCH(NCH), .BASE_W(BASE_W), .CH_W(CH_W)) u_slot (
        .base_hi (base_hi),
        .chan    (chan),
        .use_alt (use_alt),
        .slot    (slot_w)
    );

    // side 0 = source, side 1 = destination
    for (genvar g = 0; g < 2; g++) begin : g_side
        dxe_item_addr u_item (
            .end_ptr (end_q[g]),
            .remain  (cfg_q.remain),
            .size    (cfg_q.size),
            .step    ((g == 0) ? cfg_q.src_step : cfg_q.dst_step),
            .addr    (cur_a[g])
        );
    end

    always_comb begin
        mem_req   = (st_q != ST_IDLE);
        mem_we    = 1'b0;
        mem_addr  = slot_q;
        mem_wdata = '0;
        mem_size  = SZ_WORD;
        case (st_q)
            ST_GET_SRC: mem_addr = slot_q + OFF_SRC;
            ST_GET_DST: mem_addr = slot_q + OFF_DST;
            ST_GET_CFG: mem_addr = slot_q + OFF_CFG;
            ST_READ: begin
                mem_addr = cur_a[0];
                mem_size = cfg_q.size;
            end
            ST_WRITE: begin
                mem_addr  = cur_a[1];
                mem_we    = 1'b1;
                mem_wdata = data_q;
                mem_size  = cfg_q.size;
            end
            ST_UPDATE: begin
                mem_addr  = slot_q + OFF_CFG;
                mem_we    = 1'b1;
                mem_wdata = cfg_nx;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            slot_q   <= '0;
            end_q[0] <= '0;
            end_q[1] <= '0;
            data_q   <= '0;
            cfg_q    <= '0;
            done     <= 1'b0;
            err      <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            if (st_q == ST_IDLE) begin
                if (start) begin
                    slot_q <= slot_w;
                    st_q   <= ST_GET_SRC;
                end
            end else if (beat) begin
                if (mem_err) begin
                    st_q <= ST_IDLE;
                    err  <= 1'b1;
                end else begin
                    case (st_q)
                        ST_GET_SRC: begin
                            end_q[0] <= mem_rdata;
                            st_q     <= ST_GET_DST;
                        end
                        ST_GET_DST: begin
                            end_q[1] <= mem_rdata;
                            st_q     <= ST_GET_CFG;
                        end
                        ST_GET_CFG: begin
                            cfg_q <= cfg_in;
                            if (cfg_in.mode == 2'b00) begin
                                st_q <= ST_IDLE;
                                err  <= 1'b1;
                            end else begin
                                st_q <= ST_READ;
                            end
                        end
                        ST_READ: begin
                            data_q <= mem_rdata;
                            st_q   <= ST_WRITE;
                        end
                        ST_WRITE: st_q <= ST_UPDATE;
                        ST_UPDATE: begin
                            cfg_q <= cfg_nx;
                            if (cfg_q.remain == '0) begin
                                st_q <= ST_IDLE;
                                done <= 1'b1;
                            end else begin
                                st_q <= ST_READ;
                            end
                        end
                        default: st_q <= ST_IDLE;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/dxe_engine_chk.sv
module dxe_engine_chk (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        done,
    input logic        err,
    input logic        mem_req,
    input logic        mem_we,
    input logic        mem_ack,
    input logic        mem_err,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic [1:0]  mem_size
);
    a_r9_req_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata) && $stable(mem_size)));

    a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r5_done_err_excl: assert property (@(posedge clk) disable iff (rst)
        !(done && err));

    a_r7_err_next: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack && mem_err) |=> err);

    a_r7_err_idle: assert property (@(posedge clk) disable iff (rst)
        err |-> (!busy && !mem_req));

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req);

    a_r8_busy_holds: assert property (@(posedge clk) disable iff (rst)
        (busy && !mem_ack) |=> busy);
endmodule

bind dxe_engine dxe_engine_chk u_chk (.*);

// File: tb/dxe_engine_test.sv
`timescale 1ns/1ps
module dxe_engine_test;
    import dxe_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        start = 1'b0;
    logic [3:0]  chan = '0;
    logic        use_alt = 1'b0;
    logic [22:0] base_hi = '0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [1:0]  mem_size;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mem_err = 1'b0;
    logic        busy, done, err;

    always #2.5 clk = ~clk;

    dxe_engine uut (
        .clk(clk), .rst(rst), .start(start), .chan(chan), .use_alt(use_alt),
        .base_hi(base_hi), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_size(mem_size), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .mem_err(mem_err), .busy(busy), .done(done), .err(err)
    );

    typedef struct {
        logic        we;
        logic [31:0] addr;
        logic [31:0] data;
        logic [1:0]  size;
        string       tag;
    } beat_t;

    beat_t       expq[$];
    beat_t       e;
    logic [31:0] mem [logic [31:0]];
    int          checks = 0;
    int          fails = 0;
    int          done_seen = 0;
    int          err_seen = 0;
    bit          slow = 1'b0;
    bit          flip = 1'b0;
    logic [31:0] bad_addr = 32'hFFFF_FFFF;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic push(input logic we, input logic [31:0] a, input logic [31:0] d,
                        input logic [1:0] sz, input string tag);
        beat_t b;
        b.we = we; b.addr = a; b.data = d; b.size = sz; b.tag = tag;
        expq.push_back(b);
    endtask

    // memory model and scoreboard monitor
    always @(negedge clk) begin
        if (done) done_seen++;
        if (err)  err_seen++;
        mem_ack = 1'b0;
        mem_err = 1'b0;
        flip = ~flip;
        if (mem_req && (!slow || flip)) begin
            mem_ack = 1'b1;
            if (mem_we) mem[mem_addr] = mem_wdata;
            else begin
                mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
                if (mem_addr == bad_addr) mem_err = 1'b1;
            end
            checks++;
            if (expq.size() == 0) begin
                fails++;
                $display("FAIL R3: unexpected beat we=%0d addr %h, expected no beat", mem_we, mem_addr);
            end else begin
                e = expq.pop_front();
                if (e.we !== mem_we || e.addr !== mem_addr || e.size !== mem_size
                    || (e.we && e.data !== mem_wdata)) begin
                    fails++;
                    $display("FAIL %s: actual we=%0d addr %h data %h size %0d expected we=%0d addr %h data %h size %0d",
                             e.tag, mem_we, mem_addr, mem_wdata, mem_size,
                             e.we, e.addr, e.data, e.size);
                end
            end
        end
    end

    function automatic logic [31:0] mk_cfg(input int n, input int sz, input bit si,
                                           input bit di, input logic [1:0] mode);
        return {16'h0, 10'(n - 1), di, si, 2'(sz), mode};
    endfunction

    task automatic run(input int ch, input bit alt, input logic [22:0] base,
                       input logic [31:0] se, input logic [31:0] de, input logic [31:0] cfg,
                       input int fail_item, input bit poke);
        logic [31:0] slot, sa, da, d, c, last_cfg;
        int d0, e0, cnt, sz, nb;
        bit exp_done;
        slot = {base, 9'b0} + (alt ? 32'h100 : 32'h0) + 32'(ch) * 32'h10;
        mem[slot]      = se;
        mem[slot + 4]  = de;
        mem[slot + 8]  = cfg;
        mem[slot + 12] = 32'h5A5A_C0DE;
        last_cfg = cfg;
        push(1'b0, slot,     32'h0, 2'd2, "R1 source end fetch");
        push(1'b0, slot + 4, 32'h0, 2'd2, "R1 destination end fetch");
        push(1'b0, slot + 8, 32'h0, 2'd2, "R1 config fetch");
        exp_done = (cfg[1:0] != 2'b00) && (fail_item < 0);
        if (cfg[1:0] != 2'b00) begin
            cnt = int'(cfg[15:6]);
            sz  = int'(cfg[3:2]);
            nb  = 1 << sz;
            c   = cfg;
            for (int k = 0; k <= cnt; k++) begin
                int rem;
                rem = cnt - k;
                sa = cfg[4] ? se - 32'(rem * nb) : se;
                da = cfg[5] ? de - 32'(rem * nb) : de;
                if (!mem.exists(sa)) mem[sa] = 32'hC300_0000 ^ (sa * 32'd7);
                d = mem[sa];
                push(1'b0, sa, 32'h0, 2'(sz), "R2 source address");
                if (k == fail_item) begin
                    bad_addr = sa;
                    break;
                end
                push(1'b1, da, d, 2'(sz), "R3 data write");
                if (rem == 0) c[1:0] = 2'b00;
                else          c[15:6] = 10'(rem - 1);
                push(1'b1, slot + 8, c, 2'd2, (rem == 0) ? "R5 final write-back" : "R4 write-back");
                last_cfg = c;
            end
        end
        d0 = done_seen;
        e0 = err_seen;
        @(negedge clk);
        start = 1'b1; chan = 4'(ch); use_alt = alt; base_hi = base;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            start = 1'b1; chan = 4'd9; use_alt = ~alt;
            @(negedge clk);
            start = 1'b0;
        end
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk); #1;
            if (done_seen != d0 || err_seen != e0) break;
        end
        repeat (6) @(negedge clk);
        #1;
        check((done_seen - d0) == (exp_done ? 1 : 0), "R5 done pulse count",
              32'(done_seen - d0), exp_done ? 32'd1 : 32'd0);
        check((err_seen - e0) == (exp_done ? 0 : 1), "R7 err pulse count",
              32'(err_seen - e0), exp_done ? 32'd0 : 32'd1);
        check(expq.size() == 0, "R3 missing beats", 32'(expq.size()), 32'd0);
        check(mem[slot + 8] == last_cfg, "R4 stored config", mem[slot + 8], last_cfg);
        check(mem[slot + 12] == 32'h5A5A_C0DE, "R1 padding word untouched", mem[slot + 12], 32'h5A5A_C0DE);
        check(!busy && !mem_req, "R10 idle after transfer", {30'h0, busy, mem_req}, 32'h0);
        expq.delete();
        bad_addr = 32'hFFFF_FFFF;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        check(!busy,    "R10 busy after reset", {31'h0, busy}, 32'h0);
        check(!mem_req, "R10 mem_req after reset", {31'h0, mem_req}, 32'h0);
        check(!done && !err, "R10 pulses after reset", {30'h0, done, err}, 32'h0);
        @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R2 R3 R8: word items, both steps, start poked while busy
        run(3, 1'b0, 23'h00_0040, 32'h1000_010C, 32'h2000_020C, mk_cfg(4, 2, 1, 1, 2'b01), -1, 1'b1);
        // R1 alternate half, byte items, fixed destination
        run(5, 1'b1, 23'h00_0040, 32'h1000_0402, 32'h3000_0000, mk_cfg(3, 0, 1, 0, 2'b11), -1, 1'b0);
        // R5 single item (count 0), halfword, fixed source, wait states (R9)
        slow = 1'b1;
        run(0, 1'b0, 23'h00_0081, 32'h1000_0800, 32'h2000_0806, mk_cfg(1, 1, 0, 1, 2'b10), -1, 1'b0);
        slow = 1'b0;
        // R1 last alternate slot at the top of the address space
        run(15, 1'b1, 23'h7F_FFFF, 32'h1000_0C04, 32'h2000_0C04, mk_cfg(2, 2, 1, 1, 2'b01), -1, 1'b0);
        // R6 mode 0 descriptor
        run(7, 1'b0, 23'h00_0040, 32'h1000_0F00, 32'h2000_0F00, mk_cfg(2, 2, 1, 1, 2'b00), -1, 1'b0);
        // R7 error response on the second item's read
        run(2, 1'b0, 23'h00_0040, 32'h1000_1008, 32'h2000_1008, mk_cfg(3, 2, 1, 1, 2'b01), 1, 1'b0);
        // recovery after an error
        run(2, 1'b1, 23'h00_0040, 32'h1000_1104, 32'h2000_1104, mk_cfg(2, 2, 1, 1, 2'b01), -1, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule